// File: doc/BRIEF.md
# Relocatable Configuration Register Window

This block is a 64-byte window of configuration registers on an I/O bus. At first the window is dark: it decodes nothing, reads return all ones and writes go nowhere. A single 16-bit pointer port at the fixed I/O address 02EAh accepts one write after reset. That write sets the base of the window and locks the pointer. Later writes to the port are dropped until the next reset.

Once placed, the window decodes I/O addresses whose upper bits match the base. It holds byte-wide storage with fixed reset values and a write-one-to-clear status byte. It also exposes identification and strap values that come in on input ports, and it reports its own programmed base at the top of the window. Every byte of the window is exported on a flat bus, so that neighbouring timer, watchdog and clock logic can use the values.

The bus is 32 bits wide and has byte-lane enables. The low two address bits are ignored. Read data is registered and appears one cycle after the read strobe.

Top module: `cfg_window`

## Requirements
- R1: Until the pointer port has been written, every read returns FFFFFFFFh and every write outside the pointer port changes nothing.
- R2: The first write after reset to dword 02E8h that enables lane 2 or lane 3 loads io_wdata[31:16] as the base and locks the port. Any later pointer write is ignored until reset, and a new reset makes the port writable again.
- R3: Once locked, an access hits when io_addr[15:6] equals base[15:6], and io_addr[5:2] selects the dword. A read returns its four bytes little-endian (offset +0 in bits 7:0) on io_rdata one clock after io_rd.
- R4: A read that misses the window returns FFFFFFFFh.
- R5: Offsets 3Eh (low byte) and 3Fh read back the programmed base. Writes to them are dropped.
- R6: Reset values: 00h–0Bh are zero, 12h is 2Fh, dword 18h is E1040005h, dword 30h is 00000000h, dword 34h is 00000001h, and 38h is 00h.
- R7: A write changes only the bytes whose lane enable is set.
- R8: In status byte 04h, a bit clears only when lane 0 is enabled and the written bit is 1. Written zeros leave bits unchanged.
- R9: Bit i of sts_set sets status bit i, and it wins over a software clear in the same cycle.
- R10: Byte 10h returns strap_mult, 1Eh–1Fh return strap_freq, and 3Ch–3Dh return id_in. Writes to these bytes are dropped.
- R11: All other offsets, reserved ones included, read back the last value written.
- R12: regs_o[8*k+7:8*k] always carries the value that a read of offset k returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| io_be | input | 4 | Byte-lane enables |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 32 | Registered read data |
| sts_set | input | 8 | Hardware set for status byte 04h |
| id_in | input | 16 | Identification bytes for 3Ch–3Dh |
| strap_mult | input | 8 | Strap byte for 10h |
| strap_freq | input | 16 | Strap field for 1Eh–1Fh |
| regs_o | output | 512 | All 64 window bytes |

## Verification
The assertions assume that reset is held for at least one clock before activity starts. They also assume that io_rd and io_wr never target the same dword in one cycle, because the read then returns the value from before the write. The stimulus drives all strobes on falling edges and keeps them a full cycle, so every access is sampled once. It never overlaps a read with a write, and it changes id_in and the strap inputs only while idle. The set-wins case is the one place where a status set and a clearing write meet in the same cycle, and that overlap is deliberate.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

   typedef enum logic [2:0] {
      K_RW,
      K_W1C,
      K_ID,
      K_STRAP_M,
      K_STRAP_F,
      K_BASE
   } kind_e;

   // byte offset -> storage kind
   function automatic kind_e kind_of(input int off);
      case (off)
         4:       return K_W1C;
         16:      return K_STRAP_M;
         30, 31:  return K_STRAP_F;
         60, 61:  return K_ID;
         62, 63:  return K_BASE;
         default: return K_RW;
      endcase
   endfunction

   // byte offset -> reset value
   function automatic logic [7:0] rst_of(input int off);
      case (off)
         18:      return 8'h2F;
         24:      return 8'h05;
         26:      return 8'h04;
         27:      return 8'hE1;
         52:      return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/cfgwin_ptr.sv
module cfgwin_ptr #(
   parameter int          AW       = 16,
   parameter int          DB       = 4,
   parameter int unsigned PTR_ADDR = 32'h02EA
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   addr,
   input  logic [8*DB-1:0] wdata,
   input  logic [DB-1:0]   be,
   input  logic            wr,
   output logic [AW-1:0]   base,
   output logic            locked
);
   localparam int            LSB_W = $clog2(DB);
   localparam int            LANE  = PTR_ADDR % DB;
   localparam logic [AW-1:0] PTR_V = AW'(PTR_ADDR);

   if (DB < 2 || (PTR_ADDR % 2) != 0 || AW != 16) begin : g_bad_cfg
      $error("cfgwin_ptr: pointer must be a 16-bit halfword inside one bus word");
   end

   logic hit;
   wire  unused_lsb = &{1'b0, addr[LSB_W-1:0]};

   assign hit = wr && !locked
             && (addr[AW-1:LSB_W] == PTR_V[AW-1:LSB_W])
             && (be[LANE] || be[LANE+1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         base   <= '0;
      end else if (hit) begin
         locked <= 1'b1;
         base   <= wdata[8*LANE +: 16];
      end
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked); // R2
   AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(base)); // R2

endmodule

// File: rtl/cfgwin_cell.sv
module cfgwin_cell
   import cfgwin_pkg::*;
#(
   parameter kind_e      KIND = K_RW,
   parameter logic [7:0] RST  = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wd,
   input  logic [7:0] set,
   output logic [7:0] q
);
   if (KIND != K_RW && KIND != K_W1C) begin : g_bad_kind
      $error("cfgwin_cell: only stored kinds may be instantiated");
   end

   if (KIND == K_W1C) begin : g_w1c
      always_ff @(posedge clk) begin
         if (!rst_n) q <= RST;
         else        q <= (q & ~(we ? wd : 8'h00)) | set;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (|set) |=> ((q & $past(set)) == $past(set))); // R9
      AST_CLR_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         ((($past(q) & ~q) & ~$past(we ? wd : 8'h00)) == 8'h00)); // R8
   end else begin : g_rw
      always_ff @(posedge clk) begin
         if (!rst_n)  q <= RST;
         else if (we) q <= wd;
         else         q <= q | set;
      end
   end

endmodule

// File: rtl/cfg_window.sv
module cfg_window
   import cfgwin_pkg::*;
#(
   parameter int          AW        = 16,
   parameter int          DB        = 4,
   parameter int          WIN_BYTES = 64,
   parameter int unsigned PTR_ADDR  = 32'h02EA
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          io_addr,
   input  logic [8*DB-1:0]        io_wdata,
   input  logic [DB-1:0]          io_be,
   input  logic                   io_wr,
   input  logic                   io_rd,
   output logic [8*DB-1:0]        io_rdata,
   input  logic [7:0]             sts_set,
   input  logic [15:0]            id_in,
   input  logic [7:0]             strap_mult,
   input  logic [15:0]            strap_freq,
   output logic [8*WIN_BYTES-1:0] regs_o
);
   localparam int LSB_W = $clog2(DB);
   localparam int OFF_W = $clog2(WIN_BYTES);

   if (WIN_BYTES != 64) begin : g_bad_win
      $error("cfg_window: register map is defined for a 64-byte window");
   end
   if ((DB & (DB - 1)) != 0 || DB > WIN_BYTES) begin : g_bad_db
      $error("cfg_window: bus width must be a power of two bytes");
   end

   logic [AW-1:0]          base;
   logic                   locked;
   logic                   win_hit;
   logic [OFF_W-LSB_W-1:0] word_idx;
   logic [7:0]             byte_q [WIN_BYTES];
   logic [8*DB-1:0]        rd_word;
   wire                    unused_lsb = &{1'b0, io_addr[LSB_W-1:0]};

   cfgwin_ptr #(.AW(AW), .DB(DB), .PTR_ADDR(PTR_ADDR)) u_ptr (
      .clk(clk), .rst_n(rst_n), .addr(io_addr), .wdata(io_wdata),
      .be(io_be), .wr(io_wr), .base(base), .locked(locked)
   );

   assign win_hit  = locked && (io_addr[AW-1:OFF_W] == base[AW-1:OFF_W]);
   assign word_idx = io_addr[OFF_W-1:LSB_W];

   for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
      localparam kind_e K = kind_of(b);
      if (K == K_RW || K == K_W1C) begin : g_store
         logic we;
         assign we = io_wr && win_hit && (int'(word_idx) == b / DB) && io_be[b % DB];
         cfgwin_cell #(.KIND(K), .RST(rst_of(b))) u_cell (
            .clk(clk), .rst_n(rst_n), .we(we), .wd(io_wdata[8*(b%DB) +: 8]),
            .set((K == K_W1C) ? sts_set : 8'h00), .q(byte_q[b])
         );
      end else if (K == K_ID) begin : g_id
         assign byte_q[b] = id_in[8*(b-60) +: 8];
      end else if (K == K_STRAP_M) begin : g_sm
         assign byte_q[b] = strap_mult;
      end else if (K == K_STRAP_F) begin : g_sf
         assign byte_q[b] = strap_freq[8*(b-30) +: 8];
      end else begin : g_base
         assign byte_q[b] = base[8*(b-62) +: 8];
      end
      assign regs_o[8*b +: 8] = byte_q[b];
   end

   always_comb begin
      for (int l = 0; l < DB; l++) begin
         rd_word[8*l +: 8] = byte_q[{word_idx, LSB_W'(l)}];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     io_rdata <= '1;
      else if (io_rd) io_rdata <= win_hit ? rd_word : '1;
   end

   AST_DARK_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !locked) |=> (&io_rdata)); // R1
   AST_MISS_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !win_hit) |=> (&io_rdata)); // R4

endmodule

// File: tb/sim_cfg_window.sv
module sim_cfg_window;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  io_addr = '0;
   logic [31:0]  io_wdata = '0;
   logic [3:0]   io_be = '0;
   logic         io_wr = 1'b0;
   logic         io_rd = 1'b0;
   logic [31:0]  io_rdata;
   logic [7:0]   sts_set = '0;
   logic [15:0]  id_in = 16'hC3A5;
   logic [7:0]   strap_mult = 8'h5A;
   logic [15:0]  strap_freq = 16'h1234;
   logic [511:0] regs_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_d = 1'b0;

   always #2.5 clk = ~clk;

   cfg_window u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_be(io_be), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
      .sts_set(sts_set), .id_in(id_in), .strap_mult(strap_mult),
      .strap_freq(strap_freq), .regs_o(regs_o)
   );

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   // monitor: compare read data against the scoreboard
   always @(posedge clk) rd_d <= io_rd;
   always @(negedge clk) begin
      if (rd_d) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s: unexpected read data %h, expected none", "R3", io_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (io_rdata !== e) begin
               fails++;
               $display("FAIL %s: read got %h expected %h", t, io_rdata, e);
            end
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 20000", cyc);
            finish_run();
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_be = be; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_be = '0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
      checks++;
      if (got !== e) begin
         fails++;
         $display("FAIL %s: got %h expected %h", t, got, e);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      chk(io_rdata, 32'hFFFF_FFFF, "R1 reset rdata");
      // R1: dark window
      rd(16'h0000, 32'hFFFF_FFFF, "R1");
      rd(16'h0434, 32'hFFFF_FFFF, "R1");
      wr(16'h0434, 32'hAAAA_AAAA, 4'hF);
      // R2: place at 0400h
      wr(16'h02EA, 32'h0400_0000, 4'b1100);
      rd(16'h0434, 32'h0000_0001, "R1 R6 prelock write dropped");
      rd(16'h0400, 32'h0000_0000, "R6 R3");
      rd(16'h0408, 32'h0000_0000, "R6");
      rd(16'h0410, 32'h002F_005A, "R6 R10 strap_mult");
      rd(16'h0418, 32'hE104_0005, "R6");
      rd(16'h041C, 32'h1234_0000, "R10 strap_freq");
      rd(16'h043C, 32'h0400_C3A5, "R5 R10");
      rd(16'h0430, 32'h0000_0000, "R6");
      rd(16'h0438, 32'h0000_0000, "R6");
      // R2: second pointer write ignored
      wr(16'h02EA, 32'h0800_0000, 4'b1100);
      rd(16'h0800, 32'hFFFF_FFFF, "R2 relocation ignored");
      rd(16'h043C, 32'h0400_C3A5, "R2 base kept");
      // R7 lanes
      wr(16'h0430, 32'h1122_3344, 4'b0101);
      rd(16'h0430, 32'h0022_0044, "R7");
      // R5 R10 read-only
      wr(16'h043C, 32'hFFFF_FFFF, 4'hF);
      wr(16'h0410, 32'hFFFF_FFFF, 4'b0001);
      rd(16'h043C, 32'h0400_C3A5, "R5 R10 writes dropped");
      rd(16'h0410, 32'h002F_005A, "R10 strap write dropped");
      // R11 reserved storage
      wr(16'h0420, 32'hDEAD_BEEF, 4'hF);
      rd(16'h0420, 32'hDEAD_BEEF, "R11");
      // R9 hardware set
      @(negedge clk); sts_set = 8'hA5;
      @(negedge clk); sts_set = 8'h00;
      rd(16'h0404, 32'h0000_00A5, "R9 set");
      // R8 w1c
      wr(16'h0404, 32'h0000_0081, 4'b0001);
      wr(16'h0404, 32'h0000_00FF, 4'b0010);
      rd(16'h0404, 32'h0000_0024, "R8 w1c");
      // R9 set wins over clear
      @(negedge clk);
      io_addr = 16'h0404; io_wdata = 32'h0000_0004; io_be = 4'b0001;
      io_wr = 1'b1; sts_set = 8'h04;
      @(negedge clk);
      io_wr = 1'b0; io_be = '0; sts_set = 8'h00;
      rd(16'h0404, 32'h0000_0024, "R9 set wins");
      // R12 export
      @(negedge clk);
      chk(regs_o[8*8'h30 +: 32], 32'h0022_0044, "R12 dword 30h");
      chk(regs_o[8*8'h3C +: 32], 32'h0400_C3A5, "R12 dword 3Ch");
      chk(regs_o[8*8'h04 +: 8], 8'h24, "R12 status");
      // R4 misses
      rd(16'h0440, 32'hFFFF_FFFF, "R4 above");
      rd(16'h03FC, 32'hFFFF_FFFF, "R4 below");
      // R2 after re-reset
      do_reset();
      wr(16'h02EA, 32'h1240_0000, 4'b1000);
      rd(16'h127C, 32'h1240_C3A5, "R2 R5 new base");
      rd(16'h1230, 32'hFFFF_FFFF, "R4");
      rd(16'h1270, 32'h0000_0000, "R6 reset cleared");
      rd(16'h0430, 32'hFFFF_FFFF, "R4 old base gone");
      repeat (3) @(negedge clk);
      chk(exp_q.size(), 0, "R3 all reads returned");
      finish_run();
   end
endmodule